// File: doc/BRIEF.md
# Output Power-Good and Overvoltage Supervisor

This block supervises the output of a switching regulator. It advances once per switching cycle. Two digital flags come from an external window comparator. One says the sensed output is above the lower bound of the regulation window, which is about 0.51 V. The other says the output is above the upper bound, which is about 0.69 to 0.7 V. The upper flag serves both as the top edge of the power-good window and as the overvoltage trip. Both flags are first passed through a flop synchronizer. The block then qualifies them in time.

Power-good rises only after the output has stayed inside the window for a fixed number of switching cycles. It drops as soon as the synchronized flags leave the window. It is also presented as a pull-down enable for an open-drain pin. On overvoltage, the block overrides the gate drivers in a latched sequence:

- While the output is above the trip level, the high side is forced off and the low side is forced on, which discharges the output.
- Once the output falls back below the trip level, both drivers are forced off. This state holds until a reset.
- A fresh overvoltage event re-enters the discharge state.

Top module: `vwin_supervisor`

## Requirements
- R1: During and after reset, `pgood_o` is 0, `pgood_pd_o` is 1, and `hs_off_o`, `ls_on_o`, `ls_off_o` and `fault_o` are all 0.
- R2: The output counts as in-window when `cmp_lo_i`=1 and `cmp_hi_i`=0. With default parameters and both flags held, `pgood_o` is still 0 after the 257th rising edge that follows the flags entering the window. It is 1 after the 258th edge: 2 synchronizer edges plus 256 qualifying cycles.
- R3: Leaving the window drops `pgood_o` after the 2nd rising edge, which is the same cycle in which the synchronized flags show the exit. Any exit restarts qualification, so a re-entry again needs the full 258 edges.
- R4: `pgood_pd_o` is always the inverse of `pgood_o`.
- R5: When `cmp_hi_i` rises from the idle state, `hs_off_o`, `ls_on_o` and `fault_o` become 1 after the 3rd rising edge.
- R6: When `cmp_hi_i` falls during discharge, after the 3rd rising edge `ls_on_o` becomes 0 and `ls_off_o` becomes 1, while `hs_off_o` and `fault_o` stay 1.
- R7: The both-off state holds for any combination of flags with `cmp_hi_i`=0 and is left only through `rst_n` low.
- R8: When `cmp_hi_i` rises while in the both-off state, discharge is re-entered after the 3rd edge: `ls_on_o`=1 and `ls_off_o`=0.
- R9: While `fault_o` is 1, `pgood_o` stays 0 even if the flags sit inside the window far longer than the qualification time.
- R10: `ls_on_o` and `ls_off_o` are never 1 together, and `ls_on_o`=1 always comes with `hs_off_o`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Switching-cycle clock |
| rst_n | input | 1 | Asynchronous active-low supply/enable reset |
| cmp_hi_i | input | 1 | Comparator flag: output above upper/trip threshold |
| cmp_lo_i | input | 1 | Comparator flag: output above lower threshold |
| pgood_o | output | 1 | Output is qualified in regulation |
| pgood_pd_o | output | 1 | Pull-down enable for the open-drain power-good pin |
| hs_off_o | output | 1 | Force high-side driver off |
| ls_on_o | output | 1 | Force low-side driver on |
| ls_off_o | output | 1 | Force low-side driver off |
| fault_o | output | 1 | Overvoltage sequence active (latched) |

## Verification
A rising upper flag does two things: it ends power-good, because the output has left the window, and it starts the discharge override. These two effects fall one cycle apart and could be mistaken for each other. The bench raises the upper flag while power-good is high. It checks that power-good is already low after the 2nd edge while no override is yet requested, and that the override appears after the 3rd edge. The same overlap is then provoked from the latched both-off state. There, the output sits inside the window long past the qualification time, and the bench checks that power-good stays low.

// File: rtl/vwin_pkg.sv
package vwin_pkg;

   typedef enum logic [1:0] {
      OVS_IDLE  = 2'd0,
      OVS_DRAIN = 2'd1,
      OVS_SAFE  = 2'd2
   } ovs_e;

   localparam int unsigned FLAG_HI = 1;
   localparam int unsigned FLAG_LO = 0;
   localparam int unsigned N_FLAGS = 2;

endpackage

// File: rtl/vwin_sync.sv
module vwin_sync #(
   parameter int unsigned WIDTH  = 2,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("vwin_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("vwin_sync: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] chain_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[s] <= '0;
            else        chain_q[s] <= d_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[s] <= '0;
            else        chain_q[s] <= chain_q[s-1];
         end
      end
   end

   assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/vwin_qualify.sv
module vwin_qualify #(
   parameter int unsigned QUAL_CYCLES = 256
) (
   input  logic clk,
   input  logic rst_n,
   input  logic in_win_i,
   input  logic block_i,
   output logic pg_o
);

   localparam int unsigned CNT_W = $clog2(QUAL_CYCLES + 1);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(QUAL_CYCLES);

   if (QUAL_CYCLES < 1) begin : g_bad_qual
      $error("vwin_qualify: QUAL_CYCLES must be at least 1");
   end

   logic [CNT_W-1:0] cnt_q;
   logic             full;

   assign full = (cnt_q == CNT_FULL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt_q <= '0;
      else if (!in_win_i)  cnt_q <= '0;
      else if (!full)      cnt_q <= cnt_q + 1'b1;
   end

   // Immediate drop on window exit; latched fault masks the flag.
   assign pg_o = in_win_i && full && !block_i;

   // R3: any exit restarts qualification
   p_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !in_win_i |=> (cnt_q == '0));

   // R2: power-good never rises without the window held the cycle before
   p_rise_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pg_o) |-> $past(in_win_i));

   // R9: fault mask wins over a full count
   p_blocked_r9: assert property (@(posedge clk) disable iff (!rst_n)
      block_i |-> !pg_o);

endmodule

// File: rtl/vwin_ovseq.sv
module vwin_ovseq
   import vwin_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic ov_i,
   output logic hs_off_o,
   output logic ls_on_o,
   output logic ls_off_o,
   output logic fault_o
);

   ovs_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         OVS_IDLE:  if (ov_i)  state_d = OVS_DRAIN;
         OVS_DRAIN: if (!ov_i) state_d = OVS_SAFE;
         OVS_SAFE:  if (ov_i)  state_d = OVS_DRAIN;
         default:              state_d = OVS_SAFE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= OVS_IDLE;
      else        state_q <= state_d;
   end

   assign hs_off_o = (state_q != OVS_IDLE);
   assign ls_on_o  = (state_q == OVS_DRAIN);
   assign ls_off_o = (state_q == OVS_SAFE);
   assign fault_o  = (state_q != OVS_IDLE);

   // R5: a trip from idle lands in discharge
   p_trip_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == OVS_IDLE && ov_i) |=> (ls_on_o && hs_off_o));

   // R6: end of trip moves to both-off
   p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == OVS_DRAIN && !ov_i) |=> (ls_off_o && !ls_on_o));

   // R7: both-off holds without a new trip
   p_latch_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ls_off_o && !ov_i) |=> ls_off_o);

   // R8: new trip from both-off re-enters discharge
   p_rearm_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ls_off_o && ov_i) |=> ls_on_o);

   // R7: fault never clears without reset
   p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      fault_o |=> fault_o);

endmodule

// File: rtl/vwin_supervisor.sv
module vwin_supervisor
   import vwin_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned QUAL_CYCLES = 256
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cmp_hi_i,
   input  logic cmp_lo_i,
   output logic pgood_o,
   output logic pgood_pd_o,
   output logic hs_off_o,
   output logic ls_on_o,
   output logic ls_off_o,
   output logic fault_o
);

   logic [N_FLAGS-1:0] flags_raw, flags_s;
   logic               in_win_s, ov_s;
   logic               pg_int;

   assign flags_raw[FLAG_HI] = cmp_hi_i;
   assign flags_raw[FLAG_LO] = cmp_lo_i;

   vwin_sync #(
      .WIDTH  (N_FLAGS),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (flags_raw),
      .q_o   (flags_s)
   );

   assign ov_s     = flags_s[FLAG_HI];
   assign in_win_s = flags_s[FLAG_LO] && !flags_s[FLAG_HI];

   vwin_ovseq u_ovseq (
      .clk      (clk),
      .rst_n    (rst_n),
      .ov_i     (ov_s),
      .hs_off_o (hs_off_o),
      .ls_on_o  (ls_on_o),
      .ls_off_o (ls_off_o),
      .fault_o  (fault_o)
   );

   vwin_qualify #(
      .QUAL_CYCLES (QUAL_CYCLES)
   ) u_qual (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_win_i (in_win_s),
      .block_i  (fault_o),
      .pg_o     (pg_int)
   );

   assign pgood_o    = pg_int;
   assign pgood_pd_o = !pg_int;

   // R10: no shoot-through request, no conflicting low-side request
   p_no_overlap_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(ls_on_o && ls_off_o) && (!ls_on_o || hs_off_o));

   // R3: synchronized window exit drops power-good in the same cycle
   p_exit_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !in_win_s |-> !pgood_o);

   // R4: pin enable mirrors the flag
   p_od_mirror_r4: assert property (@(posedge clk) disable iff (!rst_n)
      pgood_pd_o != pgood_o);

endmodule

// File: tb/vwin_supervisor_bench.sv
`timescale 1ns/1ps
module vwin_supervisor_bench;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cmp_hi = 1'b0;
   logic cmp_lo = 1'b0;
   logic pgood, pgood_pd, hs_off, ls_on, ls_off, fault;

   int n_vec = 0;
   int n_bad = 0;
   bit done = 1'b0;

   localparam int QUAL = 256;
   localparam int SYNC = 2;
   localparam int PG_LAT = SYNC + QUAL;  // edges until power-good
   localparam int OV_LAT = SYNC + 1;     // edges until override

   always #5 clk = ~clk;

   vwin_supervisor u_vwin_supervisor (
      .clk        (clk),
      .rst_n      (rst_n),
      .cmp_hi_i   (cmp_hi),
      .cmp_lo_i   (cmp_lo),
      .pgood_o    (pgood),
      .pgood_pd_o (pgood_pd),
      .hs_off_o   (hs_off),
      .ls_on_o    (ls_on),
      .ls_off_o   (ls_off),
      .fault_o    (fault)
   );

   task automatic chk(input string tag, input logic act, input logic exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic chk_ov(input string tag, input logic e_hs, input logic e_on,
                         input logic e_off, input logic e_flt);
      chk({tag, " hs_off"}, hs_off, e_hs);
      chk({tag, " ls_on"},  ls_on,  e_on);
      chk({tag, " ls_off"}, ls_off, e_off);
      chk({tag, " fault"},  fault,  e_flt);
   endtask

   task automatic set_flags(input logic hi, input logic lo);
      @(negedge clk);
      cmp_hi = hi;
      cmp_lo = lo;
   endtask

   // wait n rising edges, then sample 2 ns after the last one
   task automatic edges(input int n);
      for (int i = 0; i < n; i++) @(posedge clk);
      #2;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      cmp_hi = 1'b0;
      cmp_lo = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   // R10 / R4: watched on every cycle
   always @(negedge clk) begin
      if (rst_n && !done) begin
         n_vec++;
         if ((ls_on && ls_off) || (ls_on && !hs_off)) begin
            n_bad++;
            $display("FAIL R10: actual ls_on=%b ls_off=%b hs_off=%b expected no overlap",
                     ls_on, ls_off, hs_off);
         end
         n_vec++;
         if (pgood_pd !== !pgood) begin
            n_bad++;
            $display("FAIL R4: actual pd=%b expected=%b", pgood_pd, !pgood);
         end
      end
   end

   initial begin
      #2_000_000;
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      // R1: reset state
      #12;
      chk("R1 pgood", pgood, 1'b0);
      chk("R1 pd", pgood_pd, 1'b1);
      chk_ov("R1", 1'b0, 1'b0, 1'b0, 1'b0);
      do_reset();
      edges(2);
      chk("R1 pgood after release", pgood, 1'b0);

      // R2: qualification time
      set_flags(1'b0, 1'b1);
      edges(PG_LAT - 1);
      chk("R2 pgood before qual", pgood, 1'b0);
      edges(1);
      chk("R2 pgood at qual", pgood, 1'b1);
      chk("R4 pd low when good", pgood_pd, 1'b0);

      // R3: exit below window
      set_flags(1'b0, 1'b0);
      edges(SYNC - 1);
      chk("R3 pgood one edge after exit", pgood, 1'b1);
      edges(1);
      chk("R3 pgood dropped", pgood, 1'b0);

      // R3: short exit restarts the count
      set_flags(1'b0, 1'b1);
      edges(100);
      set_flags(1'b0, 1'b0);
      edges(3);
      set_flags(1'b0, 1'b1);
      edges(PG_LAT - 1);
      chk("R3 restart not early", pgood, 1'b0);
      edges(1);
      chk("R3 restart full qual", pgood, 1'b1);

      // R5 with R3: trip while good; window exit precedes override by a cycle
      set_flags(1'b1, 1'b1);
      edges(SYNC);
      chk("R3 pgood drop on trip", pgood, 1'b0);
      chk_ov("R5 not yet", 1'b0, 1'b0, 1'b0, 1'b0);
      edges(1);
      chk_ov("R5 discharge", 1'b1, 1'b1, 1'b0, 1'b1);

      // R6: release to both-off
      set_flags(1'b0, 1'b1);
      edges(OV_LAT - 1);
      chk_ov("R6 still discharge", 1'b1, 1'b1, 1'b0, 1'b1);
      edges(1);
      chk_ov("R6 both off", 1'b1, 1'b0, 1'b1, 1'b1);

      // R7 / R9: latched while in window well past qualification
      edges(PG_LAT + 150);
      chk("R9 pgood masked", pgood, 1'b0);
      chk_ov("R7 held in window", 1'b1, 1'b0, 1'b1, 1'b1);
      set_flags(1'b0, 1'b0);
      edges(20);
      chk_ov("R7 held below window", 1'b1, 1'b0, 1'b1, 1'b1);

      // R8: re-arm from both-off
      set_flags(1'b1, 1'b0);
      edges(OV_LAT - 1);
      chk_ov("R8 not yet", 1'b1, 1'b0, 1'b1, 1'b1);
      edges(1);
      chk_ov("R8 rearmed", 1'b1, 1'b1, 1'b0, 1'b1);
      set_flags(1'b0, 1'b1);
      edges(OV_LAT);
      chk_ov("R6 second release", 1'b1, 1'b0, 1'b1, 1'b1);

      // R7: only reset clears
      do_reset();
      #2;
      chk_ov("R7 cleared by reset", 1'b0, 1'b0, 1'b0, 1'b0);
      chk("R1 pgood after clear", pgood, 1'b0);

      // R2/R5/R9 sweep over every flag pair, each from a clean reset
      for (int c = 0; c < 4; c++) begin
         logic hi, lo, e_pg;
         hi = c[1];
         lo = c[0];
         e_pg = lo && !hi;
         do_reset();
         set_flags(hi, lo);
         edges(PG_LAT - 1);
         chk($sformatf("R2 sweep %0d pre", c), pgood, 1'b0);
         edges(1);
         chk($sformatf("R2 sweep %0d pgood", c), pgood, e_pg);
         chk_ov($sformatf("R5 sweep %0d", c), hi, hi, 1'b0, hi);
         set_flags(1'b0, lo);
         edges(OV_LAT);
         chk_ov($sformatf("R6 sweep %0d", c), hi, 1'b0, hi, hi);
         edges(PG_LAT);
         chk($sformatf("R9 sweep %0d pgood", c), pgood, lo && !hi);
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule